// File: doc/BRIEF.md
# Static and Half-Duty LCD Drive Waveform Generator

This block turns a latched image of display bits plus a handful of control fields into the drive patterns for a direct-drive LCD glass. It produces two common lines and up to 54 segment lines. Each line is a 2-bit level code that an external analog stage converts into a voltage: `00` is low, `01` is middle and `10` is high. The code `11` is never produced. Frame timing is derived from a clock enable at the oscillator rate. A programmable ratio divides it down, and each frame is cut into four equal quarters that sequence the commons.

In static drive, one common carries a square wave and every segment either follows it (off) or opposes it (on). In half-duty, half-bias drive, the two commons take turns. Each common is driven for half a frame and rests at the middle level for the other half, so every segment pin serves two display bits. Up to the first four segment pins can be turned into plain general-purpose outputs, using a thermometer count. There are three ways to blank the panel: a segment-off control, a power-save control, and an active-low inhibit input. A compatibility mode overrides several controls and gives two fixed pins special behaviour.

Top module: `lcd_wave_gen`

## Requirements
- R1: The frame lasts the number of `osc_tick_i` pulses that `frame_sel_i` selects: 110 gives 768, 111 gives 576, 001 gives 288, 010 gives 192, and 000 or any unlisted code gives 384. Each frame is split into four quarters of equal length. The quarter counter advances only on tick pulses.
- R2: Static drive (`half_duty_i`=0). COM1 is `10` for quarters 0–1 and `00` for quarters 2–3, and COM2 stays `00`. Segment n (0-based) uses `disp_i[n]`: a 1 drives the inverse of COM1, and a 0 drives the same level as COM1.
- R3: Half-duty drive. In quarters 0 and 1, COM1 drives `10` then `00` while COM2 sits at `01`. In quarters 2 and 3, COM2 drives `10` then `00` while COM1 sits at `01`.
- R4: Half-duty segments. Segment n uses `disp_i[2n]` while COM1 is active and `disp_i[2n+1]` while COM2 is active. A 1 opposes the active common, and a 0 copies it.
- R5: `gpo_cnt_i` turns pins 0..k-1 into general-purpose outputs for k = 0..4. Codes above 4 act as 4.
- R6: A general-purpose pin drives a steady `10` or `00`. The level comes from `disp_i[n]` in static drive and from `disp_i[2n]` in half duty.
- R7: With `seg_off_i`=1, every segment pin that is not a general-purpose output shows the off pattern, and the commons keep running.
- R8: With `power_save_i`=1, the commons and segment pins are held at `00` and the divider stops. General-purpose pins keep following their data bit.
- R9: With `inhibit_ni`=0, every output, general-purpose pins included, is `00` and the divider stops.
- R10: With `compat_i`=1, the block forces the 384 ratio and no general-purpose pins, and it ignores `seg_off_i` and `power_save_i`. Segment 23 is held at `00`. In half duty, segment 53 shows the all-on pattern.
- R11: Reset, and any cycle in which the divider is stopped, returns it to the start of quarter 0. Once it runs again, quarter 0 lasts a full quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle enable at the oscillator rate |
| inhibit_ni | input | 1 | Display inhibit, active low |
| disp_i | input | 108 | Display bits; bit k is display bit k+1 |
| frame_sel_i | input | 3 | Frame ratio code |
| gpo_cnt_i | input | 3 | Number of general-purpose pins |
| half_duty_i | input | 1 | 0 selects static drive, 1 selects half duty |
| seg_off_i | input | 1 | Forces the segment off pattern |
| power_save_i | input | 1 | Power-save blanking |
| compat_i | input | 1 | Compatibility mode |
| com1_o | output | 2 | COM1 level code |
| com2_o | output | 2 | COM2 level code |
| seg_o | output | 108 | Segment n level code at bits [2n+1:2n] |

## Verification
The bench measures the frame length for every ratio code, including an unlisted one, from the spacing of COM1 rising edges. A wrong divide constant or an off-by-one wrap shows up as a shifted period. In half duty it flips every display bit of a pin separately: a design that swaps the bit taken for COM1 with the one for COM2 shows segment phases that are inverted in half of each frame. It runs power save with toggling data on ports to catch a design that blanks the general-purpose pins or leaves the commons running. It also runs compatibility mode with every overridden control asserted, which exposes any override that was not applied, along with the special behaviour of pins 23 and 53.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  localparam int unsigned QTR_MAX  = 192;
  localparam int unsigned QTR_BASE = 96;

  // quarter length in oscillator ticks; unlisted codes use the base ratio
  function automatic int unsigned qtr_len(input logic [2:0] sel);
    case (sel)
      3'b110:  return 192;
      3'b111:  return 144;
      3'b001:  return 72;
      3'b010:  return 48;
      default: return QTR_BASE;
    endcase
  endfunction

  function automatic lvl_e inv_lvl(input lvl_e l);
    case (l)
      LVL_HIGH: return LVL_LOW;
      LVL_LOW:  return LVL_HIGH;
      default:  return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/lcd_frame_div.sv
module lcd_frame_div
  import lcd_wave_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [2:0] frame_sel_i,
  input  logic       force_base_i,
  output logic [1:0] quarter_o
);

  localparam int unsigned CNT_W = $clog2(QTR_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       qtr_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    if (force_base_i) last_cnt = CNT_W'(QTR_BASE - 1);
    else              last_cnt = CNT_W'(qtr_len(frame_sel_i) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      qtr_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      qtr_q <= '0;
    end else if (tick_i) begin
      // >= so a ratio change mid-quarter wraps cleanly
      if (cnt_q >= last_cnt) begin
        cnt_q <= '0;
        qtr_q <= qtr_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign quarter_o = qtr_q;

  assert_halt_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (qtr_q == 2'd0 && cnt_q == '0));

  assert_tick_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> ($stable(qtr_q) && $stable(cnt_q)));

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_wave_pkg::*;
(
  input  logic [1:0] quarter_i,
  input  logic       half_i,
  input  logic       blank_i,
  output lvl_e       act_lvl_o,
  output logic       sel2_o,
  output lvl_e       com1_o,
  output lvl_e       com2_o
);

  always_comb begin
    if (half_i) begin
      act_lvl_o = quarter_i[0] ? LVL_LOW : LVL_HIGH;
      sel2_o    = quarter_i[1];
      com1_o    = sel2_o ? LVL_MID : act_lvl_o;
      com2_o    = sel2_o ? act_lvl_o : LVL_MID;
    end else begin
      act_lvl_o = quarter_i[1] ? LVL_LOW : LVL_HIGH;
      sel2_o    = 1'b0;
      com1_o    = act_lvl_o;
      com2_o    = LVL_LOW;
    end
    if (blank_i) begin
      com1_o = LVL_LOW;
      com2_o = LVL_LOW;
    end
  end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_wave_pkg::*;
#(
  parameter int unsigned NUM_SEG  = 54,
  parameter int unsigned NUM_GPO  = 4,
  parameter int unsigned HOLD_PIN = 23
) (
  input  logic [2*NUM_SEG-1:0] disp_i,
  input  logic                 half_i,
  input  lvl_e                 act_lvl_i,
  input  logic                 sel2_i,
  input  logic                 seg_off_i,
  input  logic                 blank_i,
  input  logic                 inhibit_i,
  input  logic [2:0]           gpo_cnt_i,
  input  logic                 compat_i,
  output logic [2*NUM_SEG-1:0] seg_o
);

  localparam int unsigned ALLON_PIN = NUM_SEG - 1;

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_pin
    logic bit_on;
    logic is_gpo;
    logic gpo_hi;
    lvl_e wave;
    lvl_e pin_lvl;

    if (n < NUM_GPO) begin : g_gpo
      assign is_gpo = (gpo_cnt_i > 3'(n));
      assign gpo_hi = half_i ? disp_i[2*n] : disp_i[n];
    end else begin : g_plain
      assign is_gpo = 1'b0;
      assign gpo_hi = 1'b0;
    end

    assign bit_on = half_i ? (sel2_i ? disp_i[2*n+1] : disp_i[2*n]) : disp_i[n];

    always_comb begin
      wave = (bit_on && !seg_off_i) ? inv_lvl(act_lvl_i) : act_lvl_i;
      if (compat_i && n == HOLD_PIN)              wave = LVL_LOW;
      if (compat_i && half_i && n == ALLON_PIN)   wave = inv_lvl(act_lvl_i);
      if (inhibit_i)    pin_lvl = LVL_LOW;
      else if (is_gpo)  pin_lvl = gpo_hi ? LVL_HIGH : LVL_LOW;
      else if (blank_i) pin_lvl = LVL_LOW;
      else              pin_lvl = wave;
    end

    assign seg_o[2*n +: 2] = pin_lvl;
  end

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcd_wave_pkg::*;
#(
  parameter int unsigned NUM_SEG  = 54,
  parameter int unsigned NUM_GPO  = 4,
  parameter int unsigned HOLD_PIN = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_tick_i,
  input  logic                 inhibit_ni,
  input  logic [2*NUM_SEG-1:0] disp_i,
  input  logic [2:0]           frame_sel_i,
  input  logic [2:0]           gpo_cnt_i,
  input  logic                 half_duty_i,
  input  logic                 seg_off_i,
  input  logic                 power_save_i,
  input  logic                 compat_i,
  output logic [1:0]           com1_o,
  output logic [1:0]           com2_o,
  output logic [2*NUM_SEG-1:0] seg_o
);

  logic       ps_eff;
  logic       halted;
  logic       seg_off_eff;
  logic [2:0] gpo_eff;
  logic [1:0] quarter;
  logic       sel2;
  lvl_e       act_lvl;
  lvl_e       com1;
  lvl_e       com2;

  assign ps_eff      = power_save_i && !compat_i;
  assign seg_off_eff = seg_off_i && !compat_i;
  assign halted      = !inhibit_ni || ps_eff;

  always_comb begin
    if (compat_i)                    gpo_eff = 3'd0;
    else if (gpo_cnt_i > 3'(NUM_GPO)) gpo_eff = 3'(NUM_GPO);
    else                             gpo_eff = gpo_cnt_i;
  end

  lcd_frame_div u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (osc_tick_i),
    .run_i        (!halted),
    .frame_sel_i  (frame_sel_i),
    .force_base_i (compat_i),
    .quarter_o    (quarter)
  );

  lcd_com_drv u_com (
    .quarter_i (quarter),
    .half_i    (half_duty_i),
    .blank_i   (halted),
    .act_lvl_o (act_lvl),
    .sel2_o    (sel2),
    .com1_o    (com1),
    .com2_o    (com2)
  );

  lcd_seg_drv #(
    .NUM_SEG  (NUM_SEG),
    .NUM_GPO  (NUM_GPO),
    .HOLD_PIN (HOLD_PIN)
  ) u_seg (
    .disp_i    (disp_i),
    .half_i    (half_duty_i),
    .act_lvl_i (act_lvl),
    .sel2_i    (sel2),
    .seg_off_i (seg_off_eff),
    .blank_i   (halted),
    .inhibit_i (!inhibit_ni),
    .gpo_cnt_i (gpo_eff),
    .compat_i  (compat_i),
    .seg_o     (seg_o)
  );

  assign com1_o = com1;
  assign com2_o = com2;

  assert_inhibit_dark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_ni |-> (com1_o == 2'b00 && com2_o == 2'b00 && seg_o == '0));

  assert_static_com2_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_duty_i |-> com2_o == 2'b00);

  assert_one_common_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted && half_duty_i) |-> ((com1_o == 2'b01) != (com2_o == 2'b01)));

  assert_ps_commons_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_eff |-> (com1_o == 2'b00 && com2_o == 2'b00));

endmodule

// File: tb/lcd_wave_gen_bench.sv
`timescale 1ns/1ps
module lcd_wave_gen_bench;

  localparam int NS = 54;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           osc_tick = 1'b0;
  logic           inh_n = 1'b1;
  logic [2*NS-1:0] disp = '0;
  logic [2:0]     fsel = 3'b000;
  logic [2:0]     gcnt = 3'd0;
  logic           half = 1'b0;
  logic           soff = 1'b0;
  logic           psave = 1'b0;
  logic           compat = 1'b0;
  logic [1:0]     com1, com2;
  logic [2*NS-1:0] seg;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt = 0;
  int m_q = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_wave_gen u_lcd_wave_gen (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .inhibit_ni(inh_n),
    .disp_i(disp), .frame_sel_i(fsel), .gpo_cnt_i(gcnt), .half_duty_i(half),
    .seg_off_i(soff), .power_save_i(psave), .compat_i(compat),
    .com1_o(com1), .com2_o(com2), .seg_o(seg)
  );

  always @(negedge clk) osc_tick <= ~osc_tick;

  function automatic int ratio_of(input logic [2:0] s, input logic c);
    if (c) return 384;
    case (s)
      3'b110: return 768;
      3'b111: return 576;
      3'b001: return 288;
      3'b010: return 192;
      default: return 384;
    endcase
  endfunction

  function automatic int inv(input int l);
    return (l == 2) ? 0 : ((l == 0) ? 2 : 1);
  endfunction

  function automatic bit m_halted();
    return !inh_n || (psave && !compat);
  endfunction

  // reference frame counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_q = 0;
    end else if (m_halted()) begin
      m_cnt = 0; m_q = 0;
    end else if (osc_tick) begin
      if (m_cnt + 1 >= ratio_of(fsel, compat) / 4) begin
        m_cnt = 0; m_q = (m_q + 1) % 4;
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit hl = m_halted();
      automatic int act = half ? ((m_q % 2) ? 0 : 2) : ((m_q < 2) ? 2 : 0);
      automatic int c2 = (half && m_q >= 2) ? 1 : 0;
      automatic int e1, e2, ports;
      automatic string ctag = !inh_n ? "R9" : (hl ? "R8" : (half ? "R3" : "R2"));
      automatic bit seg_ok = 1;
      automatic string stag = "R2";
      automatic int bad_n = 0, bad_a = 0, bad_e = 0;
      e1 = hl ? 0 : (half ? (c2 ? 1 : act) : act);
      e2 = hl ? 0 : (half ? (c2 ? act : 1) : 0);
      check(ctag, com1, e1, "com1");
      check(ctag, com2, e2, "com2");
      ports = compat ? 0 : ((gcnt > 4) ? 4 : gcnt);
      for (int n = 0; n < NS; n++) begin
        automatic int e;
        automatic string t;
        if (!inh_n) begin e = 0; t = "R9"; end
        else if (n < ports) begin
          e = (half ? disp[2*n] : disp[n]) ? 2 : 0; t = "R6";
        end else if (hl) begin e = 0; t = "R8"; end
        else if (compat && n == 23) begin e = 0; t = "R10"; end
        else if (compat && half && n == NS-1) begin e = inv(act); t = "R10"; end
        else begin
          automatic bit b = half ? disp[2*n + c2] : disp[n];
          automatic bit on = b && !(soff && !compat);
          e = on ? inv(act) : act;
          t = (soff && !compat) ? "R7" : (half ? "R4" : "R2");
        end
        if (seg_ok && int'(seg[2*n +: 2]) != e) begin
          seg_ok = 0; stag = t; bad_n = n; bad_a = seg[2*n +: 2]; bad_e = e;
        end
      end
      n_chk++;
      if (!seg_ok) begin
        n_fail++;
        $display("FAIL %s seg%0d actual=%0d expected=%0d t=%0t", stag, bad_n, bad_a, bad_e, $time);
      end
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic wait_rise(output bit ok);
    logic [1:0] prev;
    ok = 0;
    prev = com1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (prev == 2'b00 && com1 == 2'b10) begin ok = 1; break; end
      prev = com1;
    end
  endtask

  // R1: frame length from COM1 rise spacing (tick every 2 cycles)
  task automatic measure(input logic [2:0] s, input int exp_ratio);
    bit ok;
    int cnt;
    logic [1:0] prev;
    @(negedge clk); #1 fsel = s;
    wait_rise(ok);
    wait_rise(ok);
    cnt = 0;
    prev = com1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cnt++;
      if (prev == 2'b00 && com1 == 2'b10) break;
      prev = com1;
    end
    check("R1", cnt, 2 * exp_ratio, "frame cycles");
    #1;
  endtask

  task automatic rnd_disp();
    for (int i = 0; i < 2*NS; i++) disp[i] = $urandom_range(0, 1);
  endtask

  initial begin
    #1;
    cyc(3);
    check("R11", com1, 2, "com1 in reset");
    check("R11", com2, 0, "com2 in reset");
    rst_n = 1'b1;
    rnd_disp();
    // R1 ratios, plus an unlisted code
    measure(3'b110, 768);
    measure(3'b111, 576);
    measure(3'b000, 384);
    measure(3'b001, 288);
    measure(3'b010, 192);
    measure(3'b011, 384);
    fsel = 3'b010;
    // R2 static patterns
    disp = '1;                      cyc(400);
    disp = {NS{2'b01}};             cyc(400);
    rnd_disp();                     cyc(400);
    // R3/R4 half duty patterns
    half = 1'b1;
    disp = {NS{2'b01}};             cyc(400);
    disp = {NS{2'b10}};             cyc(400);
    rnd_disp();                     cyc(400);
    // R5/R6 port counts in both modes
    for (int m = 0; m < 2; m++) begin
      half = m[0];
      for (int c = 0; c < 8; c++) begin
        gcnt = 3'(c);
        rnd_disp();
        cyc(100);
      end
    end
    gcnt = 3'd0;
    // R7 segment off in both modes
    soff = 1'b1; half = 1'b0; cyc(400);
    half = 1'b1; cyc(400);
    soff = 1'b0;
    // R8 power save with ports and changing data
    gcnt = 3'd2; cyc(150);
    psave = 1'b1;
    for (int i = 0; i < 6; i++) begin rnd_disp(); cyc(30); end
    half = 1'b0;
    for (int i = 0; i < 6; i++) begin rnd_disp(); cyc(30); end
    // R11 resume from quarter 0 after halt
    psave = 1'b0; cyc(400);
    // R9 inhibit, ports included
    gcnt = 3'd4; disp = '1;
    inh_n = 1'b0; cyc(200);
    inh_n = 1'b1; half = 1'b1; cyc(400);
    // R10 compatibility with overridden controls asserted
    compat = 1'b1; soff = 1'b1; psave = 1'b1; fsel = 3'b110; gcnt = 3'd4;
    rnd_disp(); cyc(1600);
    half = 1'b0; rnd_disp(); cyc(1600);
    measure(3'b110, 384);
    half = 1'b1; disp = '0; cyc(800);
    done = 1;
    cyc(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    done = 1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule